// File: doc/BRIEF.md
# Overcurrent Fault Latch

This block supervises the two overcurrent trip inputs of a push-pull gate driver, one for the high-side switch and one for the low-side switch. Each trip input is first brought into the clock domain through two flops. It then has to stay high for a set number of consecutive clocks before it counts as an overcurrent. A qualified overcurrent on either side latches a fault. The fault stays latched while overcurrents keep arriving.

The gate control sends a one-clock strobe once per switching cycle. The block counts strobes that arrive while the fault is latched and no overcurrent is present. It drops the fault by itself after a set number of such clean cycles in a row. Two active-low control inputs clear the fault at once and block new faults while they are low: a reset/hold input and an enable input. The fault is reported open-drain style. A pull-down request goes to a shared line that floats high when nobody pulls it, so several instances can be wired together.

Top module: `ocp_fault_monitor`

## Requirements
- R1: After the asynchronous reset `rst_ni`, `pull_lo_o` is 0 and `fault_n_o` is 1.
- R2: If `trip_p_i` is held high and both control inputs are high, `pull_lo_o` is still 0 after DEGLITCH_CYC+2 rising edges have sampled the trip. It is 1 after DEGLITCH_CYC+3 such edges.
- R3: `trip_n_i` sets the fault with the same latency as R2.
- R4: A trip pulse on either side that is high for fewer than DEGLITCH_CYC consecutive clocks never sets the fault. A pulse of DEGLITCH_CYC clocks or more does set it.
- R5: A latched fault holds for as long as no cycle strobe arrives.
- R6: With no overcurrent present, a latched fault clears on the clock edge that samples the CLEAN_CYC-th strobe. After fewer strobes it stays set.
- R7: A qualified overcurrent while the fault is latched restarts the clean-cycle count from zero.
- R8: A low `hold_ni` forces `pull_lo_o` to 0 at once, without waiting for a clock edge. The fault stays cleared after `hold_ni` returns high if no trip is present.
- R9: A low `en_i` clears the fault in the same way as R8.
- R10: While `hold_ni` or `en_i` is low, an overcurrent cannot latch the fault. If the trip is still qualified when both return high, the fault sets on the next edge.
- R11: Strobes that arrive while no fault is latched do not count toward clearing a later fault.
- R12: `fault_n_o` is the inverse of `pull_lo_o`. The output only ever pulls low, so the wired line of several instances is low when any of them pulls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_ni | input | 1 | Active-low fault clear / hold-off |
| en_i | input | 1 | Enable; low clears and blocks the fault |
| trip_p_i | input | 1 | High-side overcurrent trip, asynchronous |
| trip_n_i | input | 1 | Low-side overcurrent trip, asynchronous |
| cyc_stb_i | input | 1 | One-clock strobe per switching cycle |
| pull_lo_o | output | 1 | Request to pull the shared fault line low |
| fault_n_o | output | 1 | This instance's line level, active low |

## Verification
The main instance is built with DEGLITCH_CYC=3 and CLEAN_CYC=4. At these values the bench can sweep trip pulse widths from 1 to 6 clocks on both sides, which covers every width just below and just above the qualifying threshold. It can also sweep strobe counts from 0 to 6, which spans the clear point. A second instance with DEGLITCH_CYC=2 and CLEAN_CYC=2 shares the wired fault line. This shows that the thresholds track their parameters and that either instance alone pulls the line low.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int unsigned OCP_SIDES       = 2;
  localparam int unsigned OCP_DG_DEFAULT  = 3;
  localparam int unsigned OCP_CLN_DEFAULT = 4;
  typedef logic [OCP_SIDES-1:0] trip_vec_t;
endpackage

// File: rtl/ocp_trip_filter.sv
module ocp_trip_filter #(
  parameter int unsigned DEGLITCH_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  output logic oc_o
);
  localparam int unsigned CW = $clog2(DEGLITCH_CYC + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q <= trip_i;
      s2_q <= s1_q;
      if (!s2_q)                          cnt_q <= '0;
      else if (cnt_q != CW'(DEGLITCH_CYC)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign oc_o = (cnt_q == CW'(DEGLITCH_CYC));
endmodule

// File: rtl/ocp_clean_counter.sv
module ocp_clean_counter #(
  parameter int unsigned CLEAN_CYC = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           clr_i,
  input  logic                           inc_i,
  output logic [$clog2(CLEAN_CYC+1)-1:0] cnt_o,
  output logic                           done_o
);
  localparam int unsigned CW = $clog2(CLEAN_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (clr_i || done_o)              cnt_q <= '0;
    else if (inc_i)                        cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = inc_i && !clr_i && (cnt_q == CW'(CLEAN_CYC - 1));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ocp_fault_monitor.sv
module ocp_fault_monitor
  import ocp_pkg::*;
#(
  parameter int unsigned DEGLITCH_CYC = OCP_DG_DEFAULT,
  parameter int unsigned CLEAN_CYC    = OCP_CLN_DEFAULT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_ni,
  input  logic en_i,
  input  logic trip_p_i,
  input  logic trip_n_i,
  input  logic cyc_stb_i,
  output logic pull_lo_o,
  output logic fault_n_o
);
  localparam int unsigned CW = $clog2(CLEAN_CYC + 1);

  trip_vec_t     trip_vec, oc_vec;
  logic          oc_any, clr, fault_q, clean_done;
  logic [CW-1:0] clean_cnt;

  assign trip_vec = {trip_n_i, trip_p_i};

  for (genvar g = 0; g < OCP_SIDES; g++) begin : g_side
    ocp_trip_filter #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .trip_i(trip_vec[g]),
      .oc_o  (oc_vec[g])
    );
  end

  assign oc_any = |oc_vec;
  assign clr    = !hold_ni || !en_i;

  // counts only strobes seen while latched and clean
  ocp_clean_counter #(.CLEAN_CYC(CLEAN_CYC)) u_clean (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr || oc_any || !fault_q),
    .inc_i (cyc_stb_i),
    .cnt_o (clean_cnt),
    .done_o(clean_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         fault_q <= 1'b0;
    else if (clr)        fault_q <= 1'b0;
    else if (oc_any)     fault_q <= 1'b1;
    else if (clean_done) fault_q <= 1'b0;
  end

  // clear inputs act without waiting for an edge
  assign pull_lo_o = fault_q && !clr;
  assign fault_n_o = !pull_lo_o;
endmodule

// File: rtl/ocp_fault_monitor_chk.sv
module ocp_fault_monitor_chk #(
  parameter int unsigned CLEAN_CYC = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           hold_ni,
  input logic                           en_i,
  input logic                           cyc_stb_i,
  input logic                           oc_any,
  input logic [$clog2(CLEAN_CYC+1)-1:0] clean_cnt,
  input logic                           pull_lo_o,
  input logic                           fault_n_o
);
  assert_oc_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_any && hold_ni && en_i) |=> (pull_lo_o || !hold_ni || !en_i));

  assert_rise_needs_oc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_lo_o) |-> ($past(oc_any) || $past(!hold_ni || !en_i)));

  assert_fall_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_lo_o) |-> ($past(cyc_stb_i) || !hold_ni || !en_i || $past(!hold_ni || !en_i)));

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clean_cnt < ($clog2(CLEAN_CYC+1))'(CLEAN_CYC));

  assert_held_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_ni || !en_i) |-> !pull_lo_o);

  assert_level_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_n_o != pull_lo_o);
endmodule

bind ocp_fault_monitor ocp_fault_monitor_chk #(.CLEAN_CYC(CLEAN_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hold_ni  (hold_ni),
  .en_i     (en_i),
  .cyc_stb_i(cyc_stb_i),
  .oc_any   (oc_any),
  .clean_cnt(clean_cnt),
  .pull_lo_o(pull_lo_o),
  .fault_n_o(fault_n_o)
);

// File: tb/ocp_fault_monitor_test.sv
`timescale 1ns/1ps
module ocp_fault_monitor_test;
  localparam int DG = 3, CL = 4, DGB = 2, CLB = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, hold_n = 1'b1, en = 1'b1;
  logic tp = 1'b0, tn = 1'b0, stb = 1'b0, tpb = 1'b0, stbb = 1'b0;
  logic zero = 1'b0;
  logic pa, fa_n, pb, fb_n;
  logic line;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  ocp_fault_monitor #(.DEGLITCH_CYC(DG), .CLEAN_CYC(CL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hold_ni(hold_n), .en_i(en),
    .trip_p_i(tp), .trip_n_i(tn), .cyc_stb_i(stb),
    .pull_lo_o(pa), .fault_n_o(fa_n));

  ocp_fault_monitor #(.DEGLITCH_CYC(DGB), .CLEAN_CYC(CLB)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .hold_ni(hold_n), .en_i(en),
    .trip_p_i(tpb), .trip_n_i(zero), .cyc_stb_i(stbb),
    .pull_lo_o(pb), .fault_n_o(fb_n));

  assign line = !(pa || pb);

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic flush();
    tp = 0; tn = 0; tpb = 0;
    repeat (8) tick();
  endtask

  task automatic clear_all();
    hold_n = 0; tick(); hold_n = 1; tick();
  endtask

  task automatic set_fault();
    tp = 1; repeat (DG + 3) tick(); flush();
  endtask

  task automatic strobe();
    stb = 1; tick(); stb = 0; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #7; rst_n = 1; tick();
    check("R1 pull", pa, 0);
    check("R1 level", fa_n, 1);
    check("R1 line", line, 1);

    // R2 latency on P side
    tp = 1; repeat (DG + 2) tick();
    check("R2 before", pa, 0);
    tick();
    check("R2 set", pa, 1);
    flush(); clear_all();

    // R3 latency on N side
    tn = 1; repeat (DG + 2) tick();
    check("R3 before", pa, 0);
    tick();
    check("R3 set", pa, 1);
    flush(); clear_all();

    // R4 width sweep both sides
    for (int side = 0; side < 2; side++)
      for (int w = 1; w <= 6; w++) begin
        if (side == 0) tp = 1; else tn = 1;
        repeat (w) tick();
        flush();
        check($sformatf("R4 side%0d w%0d", side, w), pa, w >= DG);
        clear_all();
      end

    // R5 hold without strobes
    set_fault();
    repeat (50) tick();
    check("R5 hold", pa, 1);
    clear_all();

    // R6 strobe sweep
    for (int n = 0; n <= 6; n++) begin
      set_fault();
      for (int k = 0; k < n; k++) strobe();
      check($sformatf("R6 n%0d", n), pa, n < CL);
      clear_all();
    end

    // R7 overcurrent restarts count
    set_fault();
    repeat (CL - 1) strobe();
    tp = 1; repeat (DG + 3) tick(); flush();
    check("R7 still set", pa, 1);
    repeat (CL - 1) strobe();
    check("R7 not yet", pa, 1);
    strobe();
    check("R7 cleared", pa, 0);

    // R8 hold clears without an edge
    set_fault();
    hold_n = 0; #1;
    check("R8 immediate", pa, 0);
    tick(); hold_n = 1; #1;
    check("R8 after", pa, 0);
    tick();
    check("R8 stays", pa, 0);

    // R9 enable clears without an edge
    set_fault();
    en = 0; #1;
    check("R9 immediate", pa, 0);
    tick(); en = 1; tick();
    check("R9 stays", pa, 0);

    // R10 blocked while held, sets on release
    hold_n = 0; tp = 1; repeat (10) tick();
    check("R10 blocked", pa, 0);
    hold_n = 1; #1;
    check("R10 no latch", pa, 0);
    tick();
    check("R10 release", pa, 1);
    flush(); en = 0; tp = 1; repeat (10) tick();
    check("R10 en blocked", pa, 0);
    en = 1; tick();
    check("R10 en release", pa, 1);
    flush(); clear_all();

    // R11 idle strobes not counted
    repeat (3) strobe();
    set_fault();
    repeat (CL - 1) strobe();
    check("R11 not early", pa, 1);
    strobe();
    check("R11 clears", pa, 0);

    // R12 wired line and second parameter set
    tpb = 1; repeat (DGB + 3) tick(); tpb = 0; repeat (8) tick();
    check("R12 b pulls", pb, 1);
    check("R12 a idle", pa, 0);
    check("R12 line low", line, 0);
    check("R12 b level", fb_n, 0);
    stbb = 1; tick(); stbb = 0; tick();
    check("R12 b one strobe", pb, 1);
    stbb = 1; tick(); stbb = 0; tick();
    check("R12 b cleared", pb, 0);
    check("R12 line high", line, 1);
    set_fault();
    check("R12 a pulls", line, 0);
    check("R12 a level", fa_n, 0);
    clear_all();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule